// File: doc/BRIEF.md
# Addressed UART Frame Slave Decoder

This block sits on the receive and transmit byte streams of one slave on a shared, multi-drop UART bus that carries up to sixteen slaves. It watches the received bytes for a frame start and then reads the frame: a header byte with the destination address and frame options, a register address, a payload of 1, 4, 16 or 24 bytes for writes, and a CRC byte. If the CRC is correct and the frame is meant for this slave, the block replays the payload as one register write strobe per cycle, or raises a read request. It then answers with one status byte that copies the error-flag register.

The block compares the frame against a 4-bit slave address. That address comes from four strap pins or from an internal 4-bit register, and a select input chooses which one is used. A broadcast write is carried out by every slave, and no slave answers it. If the line goes quiet in the middle of a frame for longer than a programmable number of bit times, the partial frame is dropped and the block waits for a new start byte.

Top module: `uf_frame_slave`

## Requirements
- R1: A frame starts only with the byte 0x55, received while waiting. Any other byte received while waiting is dropped, and the block keeps waiting.
- R2: Header byte fields: bit 7 is read (1) or write (0). Bit 6 is broadcast. Bits 5:4 are the burst code, where 00, 01, 10 and 11 give 1, 4, 16 and 24 bytes. Bits 3:0 are the destination address. A write frame carries that many payload bytes. A read frame carries no payload.
- R3: The CRC is CRC-8 with polynomial 0x07 and start value 0xFF, processed MSB first. It covers the header byte, the register-address byte and every payload byte, and does not cover the start byte.
- R4: After a valid write to this slave, wr_en_o is high for N consecutive cycles, starting the cycle after the CRC byte is received. Strobe i carries address (register address + i) mod 256 and payload byte i.
- R5: After a valid non-broadcast write to this slave, tx_valid_o pulses for one cycle, in the cycle after the last strobe. tx_byte_o carries err_flags_i.
- R6: After a valid non-broadcast read to this slave, rd_req_o and tx_valid_o pulse together for one cycle, in the cycle after the CRC byte. rd_addr_o is the register address, rd_len_o is the burst length, and tx_byte_o carries err_flags_i.
- R7: On a CRC mismatch, crc_err_o pulses for one cycle, and there is no write strobe, no read request and no status byte.
- R8: A frame with a valid CRC for a different address is read through to its end and causes no output activity.
- R9: A broadcast write with a valid CRC is carried out as in R4 and sends no status byte. A broadcast read has no effect.
- R10: With int_addr_sel_i = 1, the slave address is the internal address register. With int_addr_sel_i = 0, it is addr_pins_i, and the register has no effect.
- R11: The internal address register resets to 0x0. It loads addr_reg_d_i on a cycle in which addr_reg_we_i is high.
- R12: In the middle of a frame, bit_tick_i pulses are counted from the last received byte. When the count reaches a non-zero idle_limit_i, the frame is dropped and the block waits for 0x55 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle pulse: a received byte is present |
| rx_byte_i | input | 8 | Received byte |
| bit_tick_i | input | 1 | One pulse per bit time |
| idle_limit_i | input | IDLE_W | Idle timeout in bit times, 0 turns the timeout off |
| addr_pins_i | input | 4 | Strapped slave address |
| int_addr_sel_i | input | 1 | 1: use the internal register, 0: use the pins |
| addr_reg_we_i | input | 1 | Write enable for the internal address register |
| addr_reg_d_i | input | 4 | Value loaded into the internal address register |
| err_flags_i | input | 8 | Error-flag register value, returned as status |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 8 | Read start address |
| rd_len_o | output | 5 | Read burst length |
| tx_valid_o | output | 1 | Status byte ready to send |
| tx_byte_o | output | 8 | Status byte |
| crc_err_o | output | 1 | CRC mismatch pulse |

## Verification
Random frames mix own and foreign addresses, every burst code, reads and writes, broadcast and corrupted CRCs. This separates the acting cases from the silent ones: foreign address, broadcast read, bad CRC, and broadcast write, which acts but sends no answer. Directed frames try out the address source. The register's reset value and its loaded value are checked against contradicting strap pins. A junk byte before the start byte checks the wait state. A register address of 0xF0 with 24 bytes checks that write addresses wrap around. A partial frame followed by a long gap and then a full frame shows whether the abort happened, because without it the new start byte would be taken as payload.

// File: rtl/uf_pkg.sv
package uf_pkg;
  localparam int MAX_LEN = 24;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {ST_SYNC, ST_DEV, ST_REG, ST_DATA, ST_CRC, ST_WRITE} state_e;

  function automatic logic [7:0] crc8_step(logic [7:0] c, logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] burst_len(logic [1:0] code);
    case (code)
      2'b00: return LEN_W'(1);
      2'b01: return LEN_W'(4);
      2'b10: return LEN_W'(16);
      default: return LEN_W'(MAX_LEN);
    endcase
  endfunction
endpackage

// File: rtl/uf_addr_sel.sv
module uf_addr_sel #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_int_i,
  input  logic [AW-1:0] pins_i,
  input  logic          we_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= '0;
    else if (we_i) reg_q <= d_i;
  end

  assign addr_o = sel_int_i ? reg_q : pins_i;
endmodule

// File: rtl/uf_payload_buf.sv
module uf_payload_buf #(
  parameter int DEPTH = 24,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/uf_idle_timer.sv
module uf_idle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         byte_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!active_i || byte_i) cnt_q <= '0;
    else if (tick_i && !expired_o) cnt_q <= cnt_q + W'(1);
  end

  assign expired_o = active_i && (limit_i != '0) && (cnt_q >= limit_i);
endmodule

// File: rtl/uf_frame_slave.sv
module uf_frame_slave
  import uf_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              bit_tick_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic [3:0]        addr_pins_i,
  input  logic              int_addr_sel_i,
  input  logic              addr_reg_we_i,
  input  logic [3:0]        addr_reg_d_i,
  input  logic [7:0]        err_flags_i,
  output logic              wr_en_o,
  output logic [7:0]        wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_req_o,
  output logic [7:0]        rd_addr_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_byte_o,
  output logic              crc_err_o
);
  localparam int BUF_AW = $clog2(MAX_LEN);

  state_e            state_q;
  logic [7:0]        crc_q, reg_q, tx_byte_q;
  logic              rd_q, bc_q, rd_req_q, tx_valid_q, crc_err_q;
  logic [1:0]        burst_q;
  logic [3:0]        dst_q, my_addr;
  logic [LEN_W-1:0]  idx_q, len_w;
  logic              hit_w, last_w, parsing_w, timeout_w, buf_we;
  logic [7:0]        crc_next, buf_rdata;

  uf_addr_sel #(.AW(4)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_int_i(int_addr_sel_i), .pins_i(addr_pins_i),
    .we_i(addr_reg_we_i), .d_i(addr_reg_d_i), .addr_o(my_addr)
  );

  assign parsing_w = (state_q != ST_SYNC) && (state_q != ST_WRITE);

  uf_idle_timer #(.W(IDLE_W)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(parsing_w), .byte_i(rx_valid_i),
    .tick_i(bit_tick_i), .limit_i(idle_limit_i), .expired_o(timeout_w)
  );

  assign buf_we = (state_q == ST_DATA) && rx_valid_i;

  uf_payload_buf #(.DEPTH(MAX_LEN), .W(8)) u_buf (
    .clk_i(clk_i), .we_i(buf_we), .waddr_i(BUF_AW'(idx_q)), .wdata_i(rx_byte_i),
    .raddr_i(BUF_AW'(idx_q)), .rdata_o(buf_rdata)
  );

  assign len_w    = burst_len(burst_q);
  assign last_w   = (idx_q == len_w - LEN_W'(1));
  assign hit_w    = bc_q || (dst_q == my_addr);
  assign crc_next = crc8_step(crc_q, rx_byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SYNC;
      crc_q      <= CRC_INIT;
      reg_q      <= '0;
      rd_q       <= 1'b0;
      bc_q       <= 1'b0;
      burst_q    <= '0;
      dst_q      <= '0;
      idx_q      <= '0;
      rd_req_q   <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
      crc_err_q  <= 1'b0;
    end else begin
      rd_req_q   <= 1'b0;
      tx_valid_q <= 1'b0;
      crc_err_q  <= 1'b0;
      if (timeout_w) begin
        state_q <= ST_SYNC;
        idx_q   <= '0;
      end else begin
        unique case (state_q)
          ST_SYNC: if (rx_valid_i && rx_byte_i == SYNC_BYTE) begin
            state_q <= ST_DEV;
            crc_q   <= CRC_INIT;
          end
          ST_DEV: if (rx_valid_i) begin
            {rd_q, bc_q, burst_q, dst_q} <= rx_byte_i;
            crc_q   <= crc_next;
            state_q <= ST_REG;
          end
          ST_REG: if (rx_valid_i) begin
            reg_q   <= rx_byte_i;
            crc_q   <= crc_next;
            idx_q   <= '0;
            state_q <= rd_q ? ST_CRC : ST_DATA;
          end
          ST_DATA: if (rx_valid_i) begin
            crc_q <= crc_next;
            if (last_w) state_q <= ST_CRC;
            else idx_q <= idx_q + LEN_W'(1);
          end
          ST_CRC: if (rx_valid_i) begin
            idx_q   <= '0;
            state_q <= ST_SYNC;
            if (rx_byte_i != crc_q) crc_err_q <= 1'b1;
            else if (hit_w && !rd_q) state_q <= ST_WRITE;
            else if (hit_w && !bc_q) begin
              rd_req_q   <= 1'b1;
              tx_valid_q <= 1'b1;
              tx_byte_q  <= err_flags_i;
            end
          end
          ST_WRITE: begin
            if (last_w) begin
              state_q <= ST_SYNC;
              idx_q   <= '0;
              if (!bc_q) begin
                tx_valid_q <= 1'b1;
                tx_byte_q  <= err_flags_i;
              end
            end else idx_q <= idx_q + LEN_W'(1);
          end
          default: state_q <= ST_SYNC;
        endcase
      end
    end
  end

  assign wr_en_o    = (state_q == ST_WRITE);
  assign wr_addr_o  = reg_q + 8'(idx_q);
  assign wr_data_o  = buf_rdata;
  assign rd_req_o   = rd_req_q;
  assign rd_addr_o  = reg_q;
  assign rd_len_o   = len_w;
  assign tx_valid_o = tx_valid_q;
  assign tx_byte_o  = tx_byte_q;
  assign crc_err_o  = crc_err_q;
endmodule

// File: rtl/uf_frame_slave_chk.sv
module uf_frame_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] err_flags_i,
  input logic       wr_en_o,
  input logic [7:0] wr_addr_o,
  input logic       rd_req_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_byte_o,
  input logic       crc_err_o
);
  assert_one_action_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, rd_req_o, crc_err_o}));

  assert_crc_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> (!tx_valid_o && !wr_en_o));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 8'd1));

  assert_status_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_byte_o == $past(err_flags_i)));

  assert_read_answer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> tx_valid_o);

  assert_status_not_in_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !tx_valid_o);
endmodule

bind uf_frame_slave uf_frame_slave_chk u_chk (.*);

// File: tb/sim_uf_frame_slave.sv
module sim_uf_frame_slave;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_LIM = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, bit_tick = 1'b1, int_sel = 1'b1, reg_we = 1'b0;
  logic [7:0] rx_byte = '0, err_flags = '0;
  logic [7:0] idle_limit = 8'(IDLE_LIM);
  logic [3:0] pins = 4'h5, reg_d = '0;
  logic wr_en, rd_req, tx_valid, crc_err;
  logic [7:0] wr_addr, wr_data, rd_addr, tx_byte;
  logic [4:0] rd_len;

  uf_frame_slave #(.IDLE_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .bit_tick_i(bit_tick), .idle_limit_i(idle_limit), .addr_pins_i(pins),
    .int_addr_sel_i(int_sel), .addr_reg_we_i(reg_we), .addr_reg_d_i(reg_d),
    .err_flags_i(err_flags), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .tx_valid_o(tx_valid),
    .tx_byte_o(tx_byte), .crc_err_o(crc_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  longint cyc = 0;
  bit done = 1'b0;
  logic [7:0] payload [24];
  logic [7:0] wr_a[$], wr_d[$], tx_b[$], rd_a[$];
  int rd_l[$];
  longint wr_t[$], tx_t[$], rd_t[$];
  int crc_errs = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin wr_a.push_back(wr_addr); wr_d.push_back(wr_data); wr_t.push_back(cyc); end
    if (tx_valid) begin tx_b.push_back(tx_byte); tx_t.push_back(cyc); end
    if (rd_req) begin rd_a.push_back(rd_addr); rd_l.push_back(int'(rd_len)); rd_t.push_back(cyc); end
    if (crc_err) crc_errs++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = x[7] ^ d[i];
      x = {x[6:0], 1'b0};
      if (fb) x = x ^ 8'h07;
    end
    return x;
  endfunction

  function automatic int ref_len(input logic [1:0] code);
    case (code) 2'd0: return 1; 2'd1: return 4; 2'd2: return 16; default: return 24; endcase
  endfunction

  task automatic clear_logs();
    wr_a.delete(); wr_d.delete(); wr_t.delete(); tx_b.delete(); tx_t.delete();
    rd_a.delete(); rd_l.delete(); rd_t.delete(); crc_errs = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] dev, input logic [7:0] ra, input bit bad);
    logic [7:0] c = 8'hFF;
    int n = dev[7] ? 0 : ref_len(dev[5:4]);
    send_byte(8'h55);
    send_byte(dev); c = ref_crc(c, dev);
    send_byte(ra);  c = ref_crc(c, ra);
    for (int i = 0; i < n; i++) begin send_byte(payload[i]); c = ref_crc(c, payload[i]); end
    send_byte(bad ? (c ^ 8'h01) : c);
    repeat (40) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] dev, input logic [7:0] ra, input bit bad,
                           input logic [3:0] my);
    bit rd = dev[7], bc = dev[6];
    int len = ref_len(dev[5:4]);
    bit hit = bc || (dev[3:0] == my);
    int exp_wr = (!bad && hit && !rd) ? len : 0;
    int exp_tx = (!bad && hit && !bc) ? 1 : 0;
    int exp_rd = (!bad && hit && rd && !bc) ? 1 : 0;
    string tag = bad ? "R7" : (!hit ? "R8" : (bc ? "R9" : (rd ? "R6" : "R4")));
    clear_logs();
    err_flags = 8'($urandom);
    send_frame(dev, ra, bad);
    chk(wr_a.size() == exp_wr, {tag, " R2 R3 write count"}, wr_a.size(), exp_wr);
    if (wr_a.size() == exp_wr)
      for (int i = 0; i < exp_wr; i++) begin
        chk(wr_a[i] == 8'(ra + 8'(i)), "R4 write address", wr_a[i], 8'(ra + 8'(i)));
        chk(wr_d[i] == payload[i], "R4 write data", wr_d[i], payload[i]);
        chk(wr_t[i] == wr_t[0] + i, "R4 consecutive strobes", wr_t[i], wr_t[0] + i);
      end
    chk(tx_b.size() == exp_tx, {tag, " R5 status count"}, tx_b.size(), exp_tx);
    if (exp_tx == 1 && tx_b.size() == 1) begin
      chk(tx_b[0] == err_flags, "R5 status byte", tx_b[0], err_flags);
      if (!rd && wr_t.size() > 0)
        chk(tx_t[0] == wr_t[wr_t.size()-1] + 1, "R5 status timing", tx_t[0], wr_t[wr_t.size()-1] + 1);
    end
    chk(rd_a.size() == exp_rd, {tag, " R6 read count"}, rd_a.size(), exp_rd);
    if (exp_rd == 1 && rd_a.size() == 1) begin
      chk(rd_a[0] == ra, "R6 read address", rd_a[0], ra);
      chk(rd_l[0] == len, "R6 read length", rd_l[0], len);
      chk(tx_t.size() == 1 && rd_t[0] == tx_t[0], "R6 read with status", rd_t[0], tx_t.size() ? tx_t[0] : -1);
    end
    chk(crc_errs == int'(bad), "R7 crc flag", crc_errs, int'(bad));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 24; i++) payload[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!wr_en && !tx_valid && !rd_req && !crc_err, "R4 reset outputs idle",
        {wr_en, tx_valid, rd_req, crc_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: register resets to 0, pins say 5
    run_frame(8'h10, 8'h20, 1'b0, 4'h0);
    // R10: pins selected
    int_sel = 1'b0;
    run_frame(8'h00, 8'h30, 1'b0, 4'h5);
    run_frame(8'h05, 8'h30, 1'b0, 4'h5);
    // R11: load register with 9
    @(negedge clk); reg_we = 1'b1; reg_d = 4'h9;
    @(negedge clk); reg_we = 1'b0;
    run_frame(8'h09, 8'h40, 1'b0, 4'h5);
    int_sel = 1'b1;
    run_frame(8'h05, 8'h40, 1'b0, 4'h9);
    run_frame(8'h29, 8'h40, 1'b0, 4'h9);
    // R1: junk before start byte
    clear_logs();
    send_byte(8'hA3); send_byte(8'h00); repeat (30) @(negedge clk);
    chk(wr_a.size() == 0 && tx_b.size() == 0 && crc_errs == 0, "R1 junk ignored",
        wr_a.size() + tx_b.size() + crc_errs, 0);
    run_frame(8'h19, 8'h50, 1'b0, 4'h9);
    // R4: address wrap
    run_frame(8'h39, 8'hF0, 1'b0, 4'h9);
    // R9: broadcast read has no effect, broadcast write silent
    run_frame(8'hC3, 8'h10, 1'b0, 4'h9);
    run_frame(8'h53, 8'h10, 1'b0, 4'h9);
    // R6 read, R7 bad crc
    run_frame(8'hA9, 8'h77, 1'b0, 4'h9);
    run_frame(8'h19, 8'h77, 1'b1, 4'h9);
    // R12: partial frame then long gap
    clear_logs();
    send_byte(8'h55); send_byte(8'h09); send_byte(8'h60); send_byte(8'h11);
    repeat (2 * IDLE_LIM) @(negedge clk);
    run_frame(8'h09, 8'h61, 1'b0, 4'h9);
    chk(crc_errs == 0, "R12 abort then clean frame", crc_errs, 0);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] dev = 8'($urandom);
      for (int i = 0; i < 24; i++) payload[i] = 8'($urandom);
      if ($urandom_range(1, 0) == 1) dev[3:0] = 4'h9;
      dev[6] = ($urandom_range(4, 0) == 0);
      run_frame(dev, 8'($urandom), ($urandom_range(6, 0) == 0), 4'h9);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule